// File: doc/BRIEF.md
# Bit-7 Status Poll Completion Engine

This block sits on the host side of a flash-style memory. After the host has issued a program or erase command sequence, it starts the engine with three things: the address to poll, the byte it wrote, and a flag that marks the operation as an erase. The engine then reads status bytes from the memory through a simple read handshake. A read request is held until the memory returns a data-valid strobe with a byte. The engine always reads at the one address it was given. When the operation is over, it reports pass or fail.

Each status byte is judged on two bits. Bit 7 is compared with the expected bit 7. For a program this is bit 7 of the written byte. For an erase it is a constant 1. If bit 7 does not match, bit 5 is the device's timeout flag. A raised timeout flag does not end the poll at once. Bit 7 may flip in the same cycle as bit 5, so the engine reads once more and judges bit 7 again before it declares failure. After any pass, the engine makes one extra read so that the returned byte is valid on all eight bits. A poll-count limit ends a run in which the timeout flag never rises.

Top module: `dpoll_engine`

## Requirements
- R1: While reset is active and in the first cycle after reset, busy_o, rd_req_o, done_o, pass_o and fail_o are all 0.
- R2: If start_i is high while the engine is idle, it is accepted. busy_o and rd_req_o are high from the next cycle, and rd_addr_o equals the addr_i value sampled with start_i.
- R3: A start_i pulse while busy_o is high has no effect. The address, the expected bit, the number of reads and the result of the run in progress stay unchanged.
- R4: The expected bit 7 is data_i[7] when erase_i is 0 and 1 when erase_i is 1. Both are sampled with the accepted start.
- R5: rd_req_o stays high until a cycle in which rd_valid_i is high. rd_data_i is used only in such cycles. rd_valid_i and rd_data_i have no effect while the engine is idle.
- R6: If bit 7 of a poll read matches, the engine makes exactly one further read. That read completes with pass, and result_o equals the byte it returned.
- R7: A poll read whose bit 7 mismatches and whose bit 5 is 0 is followed by another poll read at the same address.
- R8: A poll read whose bit 7 mismatches and whose bit 5 is 1 is followed by one recheck read. If bit 7 of the recheck matches, R6 applies. Otherwise the run ends with fail, and result_o equals the recheck byte.
- R9: If MAX_POLLS consecutive poll reads all have a mismatching bit 7 and bit 5 at 0, the run ends with fail after the last of them, and result_o equals that byte. With one read fewer, the run continues.
- R10: The end of a run is a single-cycle done_o pulse together with exactly one of pass_o and fail_o. It comes in the cycle after the final read's data-valid cycle, and busy_o is low in that cycle. pass_o and fail_o are never high without done_o.
- R11: rd_addr_o does not change while busy_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start a polling run (used only when idle) |
| addr_i | input | AW | Valid address to poll |
| data_i | input | 8 | Byte that was programmed |
| erase_i | input | 1 | 1 = erase operation, 0 = program |
| busy_o | output | 1 | Run in progress |
| rd_req_o | output | 1 | Read request, held until data-valid |
| rd_addr_o | output | AW | Read address |
| rd_valid_i | input | 1 | Read data valid strobe |
| rd_data_i | input | 8 | Returned status byte |
| done_o | output | 1 | One-cycle completion strobe |
| pass_o | output | 1 | Run passed (with done_o) |
| fail_o | output | 1 | Run failed (with done_o) |
| result_o | output | 8 | Last byte read, valid with done_o |

## Verification
The assertions check the following on every cycle: the shape of the completion strobe (one cycle, exactly one verdict, busy already dropped), the read request held across cycles without data-valid, a fixed read address during a run, no request while idle, and acceptance of a start when idle. Some behaviours depend on the sequence of bytes returned, and only the bench scenarios can show them. These are the polarity of the expected bit for program and erase, the extra read after a pass, the recheck after the timeout bit in both of its outcomes, the exact read count at the poll limit and one read below it, and the immunity to stray data-valid strobes, junk data and restarts.

// File: rtl/dpoll_pkg.sv
package dpoll_pkg;

    // Status-byte bit positions used by the judge
    localparam int STAT_BIT = 7;
    localparam int TMO_BIT  = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_POLL,
        ST_RECHECK,
        ST_FINAL
    } dp_state_e;

    typedef enum logic [1:0] {
        V_MATCH,
        V_AGAIN,
        V_TIMEOUT
    } dp_verdict_e;

    typedef struct packed {
        logic       fin;
        logic       good;
        logic [7:0] byte_v;
    } dp_end_t;

    function automatic logic expected_bit(input logic is_erase, input logic [7:0] wr_byte);
        return is_erase ? 1'b1 : wr_byte[STAT_BIT];
    endfunction

endpackage

// File: rtl/dpoll_judge.sv
module dpoll_judge
    import dpoll_pkg::*;
(
    input  logic [7:0]  stat_byte,
    input  logic        exp_bit,
    output dp_verdict_e verdict
);
    always_comb begin
        if (stat_byte[STAT_BIT] == exp_bit)
            verdict = V_MATCH;
        else if (stat_byte[TMO_BIT])
            verdict = V_TIMEOUT;
        else
            verdict = V_AGAIN;
    end
endmodule

// File: rtl/dpoll_limit.sv
module dpoll_limit #(
    parameter int MAX_POLLS = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
    localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc && cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign at_limit = (cnt == LAST);
endmodule

// File: rtl/dpoll_fsm.sv
module dpoll_fsm
    import dpoll_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    data_i,
    input  logic          erase_i,
    input  logic          rd_valid_i,
    input  logic [7:0]    rd_data_i,
    input  dp_verdict_e   verdict,
    input  logic          at_limit,
    output logic          exp_bit,
    output logic          cnt_clr,
    output logic          cnt_inc,
    output logic          busy_o,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          done_o,
    output logic          pass_o,
    output logic          fail_o,
    output logic [7:0]    result_o
);
    dp_state_e     st, st_n;
    logic [AW-1:0] addr_q;
    logic          exp_q;
    logic          load;
    logic          resp;
    dp_end_t       fin;

    assign resp = rd_valid_i && (st != ST_IDLE);

    always_comb begin
        st_n       = st;
        load       = 1'b0;
        cnt_clr    = 1'b0;
        cnt_inc    = 1'b0;
        fin.fin    = 1'b0;
        fin.good   = 1'b0;
        fin.byte_v = rd_data_i;
        unique case (st)
            ST_IDLE: begin
                if (start_i) begin
                    load    = 1'b1;
                    cnt_clr = 1'b1;
                    st_n    = ST_POLL;
                end
            end
            ST_POLL: begin
                if (resp) begin
                    unique case (verdict)
                        V_MATCH:   st_n = ST_FINAL;
                        V_TIMEOUT: st_n = ST_RECHECK;
                        default: begin
                            if (at_limit) begin
                                fin.fin = 1'b1;
                                st_n    = ST_IDLE;
                            end else begin
                                cnt_inc = 1'b1;
                            end
                        end
                    endcase
                end
            end
            ST_RECHECK: begin
                if (resp) begin
                    if (verdict == V_MATCH) begin
                        st_n = ST_FINAL;
                    end else begin
                        fin.fin = 1'b1;
                        st_n    = ST_IDLE;
                    end
                end
            end
            ST_FINAL: begin
                if (resp) begin
                    fin.fin  = 1'b1;
                    fin.good = 1'b1;
                    st_n     = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            addr_q   <= '0;
            exp_q    <= 1'b0;
            done_o   <= 1'b0;
            pass_o   <= 1'b0;
            fail_o   <= 1'b0;
            result_o <= '0;
        end else begin
            st     <= st_n;
            done_o <= fin.fin;
            pass_o <= fin.fin && fin.good;
            fail_o <= fin.fin && !fin.good;
            if (fin.fin)
                result_o <= fin.byte_v;
            if (load) begin
                addr_q <= addr_i;
                exp_q  <= expected_bit(erase_i, data_i);
            end
        end
    end

    assign exp_bit   = exp_q;
    assign busy_o    = (st != ST_IDLE);
    assign rd_req_o  = (st != ST_IDLE);
    assign rd_addr_o = addr_q;
endmodule

// File: rtl/dpoll_engine.sv
module dpoll_engine
    import dpoll_pkg::*;
#(
    parameter int AW        = 24,
    parameter int MAX_POLLS = 1024
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    data_i,
    input  logic          erase_i,
    output logic          busy_o,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_valid_i,
    input  logic [7:0]    rd_data_i,
    output logic          done_o,
    output logic          pass_o,
    output logic          fail_o,
    output logic [7:0]    result_o
);
    dp_verdict_e verdict;
    logic        exp_bit;
    logic        cnt_clr;
    logic        cnt_inc;
    logic        at_limit;

    dpoll_judge u_judge (
        .stat_byte (rd_data_i),
        .exp_bit   (exp_bit),
        .verdict   (verdict)
    );

    dpoll_limit #(.MAX_POLLS(MAX_POLLS)) u_limit (
        .clk      (clk),
        .rst      (rst),
        .clr      (cnt_clr),
        .inc      (cnt_inc),
        .at_limit (at_limit)
    );

    dpoll_fsm #(.AW(AW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .addr_i     (addr_i),
        .data_i     (data_i),
        .erase_i    (erase_i),
        .rd_valid_i (rd_valid_i),
        .rd_data_i  (rd_data_i),
        .verdict    (verdict),
        .at_limit   (at_limit),
        .exp_bit    (exp_bit),
        .cnt_clr    (cnt_clr),
        .cnt_inc    (cnt_inc),
        .busy_o     (busy_o),
        .rd_req_o   (rd_req_o),
        .rd_addr_o  (rd_addr_o),
        .done_o     (done_o),
        .pass_o     (pass_o),
        .fail_o     (fail_o),
        .result_o   (result_o)
    );
endmodule

// File: rtl/dpoll_checker.sv
module dpoll_checker #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          busy_o,
    input logic          rd_req_o,
    input logic          rd_valid_i,
    input logic [AW-1:0] rd_addr_o,
    input logic          done_o,
    input logic          pass_o,
    input logic          fail_o
);
    a_r1_idle_no_req: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !rd_req_o);

    a_r2_start_taken: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> busy_o);

    a_r5_req_held: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && !rd_valid_i) |=> rd_req_o);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r10_one_verdict: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (pass_o ^ fail_o));

    a_r10_no_stray_verdict: assert property (@(posedge clk) disable iff (rst)
        (pass_o || fail_o) |-> done_o);

    a_r10_idle_at_done: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    a_r11_addr_held: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));
endmodule

bind dpoll_engine dpoll_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .rd_req_o   (rd_req_o),
    .rd_valid_i (rd_valid_i),
    .rd_addr_o  (rd_addr_o),
    .done_o     (done_o),
    .pass_o     (pass_o),
    .fail_o     (fail_o)
);

// File: tb/sim_dpoll_engine.sv
module sim_dpoll_engine;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 16;
    localparam int MAXP       = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [7:0]    data_i = '0;
    logic          erase_i = 1'b0;
    logic          busy_o, rd_req_o, done_o, pass_o, fail_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_valid_i = 1'b0;
    logic [7:0]    rd_data_i = '0;
    logic [7:0]    result_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpoll_engine #(.AW(AW), .MAX_POLLS(MAXP)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i), .data_i(data_i),
        .erase_i(erase_i), .busy_o(busy_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .done_o(done_o),
        .pass_o(pass_o), .fail_o(fail_o), .result_o(result_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Memory responder
    logic [7:0] resp_q[$];
    int         gap_cfg = 0;
    int         gap_cnt = 0;
    int         reads_seen = 0;
    bit         spur_valid = 1'b0;
    logic [7:0] junk = 8'h00;

    // Completion capture
    bit         got_done = 1'b0;
    bit         got_pass = 1'b0;
    bit         got_fail = 1'b0;
    logic [7:0] got_res  = '0;

    // Behavioural reference model
    bit         m_busy = 1'b0;
    int         m_phase = 0;
    int         m_polls = 0;
    logic [AW-1:0] m_addr = '0;
    bit         m_exp = 1'b0;
    bit         m_done = 1'b0, m_pass = 1'b0, m_fail = 1'b0;
    logic [7:0] m_res = '0;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_busy = 0; m_done = 0; m_pass = 0; m_fail = 0; m_res = '0;
        end else begin
            m_done = 0; m_pass = 0; m_fail = 0;
            if (!m_busy) begin
                if (start_i) begin
                    m_busy = 1; m_addr = addr_i; m_phase = 0; m_polls = 0;
                    m_exp = erase_i ? 1'b1 : data_i[7];
                end
            end else if (rd_valid_i) begin
                if (m_phase == 2) begin
                    m_busy = 0; m_done = 1; m_pass = 1; m_res = rd_data_i;
                end else if (rd_data_i[7] == m_exp) begin
                    m_phase = 2;
                end else if (m_phase == 1) begin
                    m_busy = 0; m_done = 1; m_fail = 1; m_res = rd_data_i;
                end else if (rd_data_i[5]) begin
                    m_phase = 1;
                end else begin
                    m_polls++;
                    if (m_polls == MAXP) begin
                        m_busy = 0; m_done = 1; m_fail = 1; m_res = rd_data_i;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(busy_o === m_busy, "R2 busy", busy_o, m_busy);
            chk(rd_req_o === m_busy, "R5 req", rd_req_o, m_busy);
            if (m_busy) chk(rd_addr_o === m_addr, "R11 addr", rd_addr_o, m_addr);
            chk({done_o, pass_o, fail_o} === {m_done, m_pass, m_fail}, "R10 done/pass/fail",
                {done_o, pass_o, fail_o}, {m_done, m_pass, m_fail});
            if (m_done) chk(result_o === m_res, "R6 result", result_o, m_res);
            if (done_o) begin
                got_done = 1; got_pass = pass_o; got_fail = fail_o; got_res = result_o;
            end
        end
        if (rd_req_o === 1'b1 && resp_q.size() > 0) begin
            if (gap_cnt >= gap_cfg) begin
                rd_valid_i = 1'b1;
                rd_data_i  = resp_q.pop_front();
                gap_cnt    = 0;
                reads_seen++;
            end else begin
                rd_valid_i = 1'b0;
                rd_data_i  = junk;
                gap_cnt++;
            end
        end else begin
            rd_valid_i = spur_valid;
            rd_data_i  = spur_valid ? 8'h80 : junk;
        end
    end

    task automatic launch(input logic [AW-1:0] a, input logic [7:0] d, input bit er);
        got_done = 0; reads_seen = 0; gap_cnt = 0;
        @(negedge clk);
        start_i = 1'b1; addr_i = a; data_i = d; erase_i = er;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!got_done && n < 500) begin
            @(negedge clk);
            n++;
        end
        if (!got_done) chk(1'b0, req, 0, 1);
        @(negedge clk);
    endtask

    task automatic expect_end(input string req, input bit pass, input int reads, input logic [7:0] res);
        chk(got_pass == pass && got_fail == !pass, req, {got_pass, got_fail}, {pass, !pass});
        chk(reads_seen == reads, req, reads_seen, reads);
        chk(got_res == res, req, got_res, res);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_o === 1'b0 && rd_req_o === 1'b0 && done_o === 1'b0, "R1 during reset",
            {busy_o, rd_req_o, done_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy_o === 1'b0 && rd_req_o === 1'b0 && done_o === 1'b0 && pass_o === 1'b0 && fail_o === 1'b0,
            "R1 after reset", {busy_o, rd_req_o, done_o, pass_o, fail_o}, 0);

        // R7 / R6: two repolls, then match, then extra read
        resp_q = '{8'h00, 8'h00, 8'h80, 8'hA5};
        launch(16'h1234, 8'h80, 1'b0);
        chk(rd_req_o === 1'b1 && rd_addr_o === 16'h1234, "R2 request at start", rd_addr_o, 16'h1234);
        wait_done("R7 timeout");
        expect_end("R7 repoll then R6 pass", 1'b1, 4, 8'hA5);

        // R4: erase expects bit 7 = 1 regardless of data_i
        resp_q = '{8'h40, 8'h80, 8'h3C};
        launch(16'h0F00, 8'h00, 1'b1);
        wait_done("R4 timeout");
        expect_end("R4 erase polarity", 1'b1, 3, 8'h3C);

        // R4: program of bit7=0 matches a 0 at once
        resp_q = '{8'h00, 8'h5E};
        launch(16'h0002, 8'h01, 1'b0);
        wait_done("R4 timeout");
        expect_end("R4 program polarity", 1'b1, 2, 8'h5E);

        // R8: timeout bit, recheck matches
        resp_q = '{8'h80, 8'hA0, 8'h20, 8'h33};
        launch(16'h0777, 8'h00, 1'b0);
        wait_done("R8 timeout");
        expect_end("R8 recheck pass", 1'b1, 4, 8'h33);

        // R8: timeout bit, recheck mismatches
        resp_q = '{8'h20, 8'h20};
        launch(16'h0888, 8'hFF, 1'b0);
        wait_done("R8 timeout");
        expect_end("R8 recheck fail", 1'b0, 2, 8'h20);

        // R9: limit reached
        resp_q = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01};
        launch(16'h0999, 8'h80, 1'b0);
        wait_done("R9 timeout");
        expect_end("R9 limit fail", 1'b0, MAXP, 8'h01);

        // R9: one below the limit still continues
        resp_q = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80, 8'h99};
        launch(16'h0AAA, 8'h80, 1'b0);
        wait_done("R9 timeout");
        expect_end("R9 below limit", 1'b1, MAXP + 1, 8'h99);

        // R5: gaps with tempting junk data between valid strobes
        gap_cfg = 2; junk = 8'h80;
        resp_q = '{8'h00, 8'h00, 8'h80, 8'h42};
        launch(16'h0BBB, 8'h80, 1'b0);
        wait_done("R5 timeout");
        expect_end("R5 sample only on valid", 1'b1, 4, 8'h42);

        // R3: restart while busy is ignored
        resp_q = '{8'h00, 8'h80, 8'h11};
        launch(16'h0CCC, 8'h80, 1'b0);
        start_i = 1'b1; addr_i = 16'h0DDD; data_i = 8'h00; erase_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        chk(rd_addr_o === 16'h0CCC, "R3 address kept", rd_addr_o, 16'h0CCC);
        wait_done("R3 timeout");
        expect_end("R3 restart ignored", 1'b1, 3, 8'h11);
        gap_cfg = 0; junk = 8'h00;

        // R5: stray valid strobes while idle
        spur_valid = 1'b1;
        repeat (4) @(negedge clk);
        chk(busy_o === 1'b0 && done_o === 1'b0, "R5 idle valid ignored", {busy_o, done_o}, 0);
        spur_valid = 1'b0;
        @(negedge clk);
        resp_q = '{8'h00, 8'h80, 8'h77};
        launch(16'h0EEE, 8'h80, 1'b0);
        wait_done("R5 timeout");
        expect_end("R5 after idle strobes", 1'b1, 3, 8'h77);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule